// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a single-way data cache placed between a requester that issues byte addresses for 32-bit words and a slower next-level memory. The number of sets and the line length in words are parameters, and both must be powers of two. A lookup is combinational, so a read hit returns its word in the cycle of the request. A miss returns a nonzero stall count. The requester waits and then presents the same request again. That retry hits once the line has been loaded.

One fill engine loads a missing line into its set, one word per cycle, in ascending word order. Before it starts reading words it counts down the next-level latency. If the next level reports its own stall, the engine reloads the countdown and resumes at the word it was waiting for. If the next level rejects an address, the error is held. A retry of that line gets the error back. A miss on any other line clears the error and restarts the engine for the new line. Writes allocate like reads and go through to the next level only on a hit. Each completed fill raises a one-cycle event that carries the tag and the set index. A debug port reports the valid bit and the tag of any chosen set.

Top module: `dm_wt_cache`

## Requirements
- R1: A byte address divides into fields as follows: bits [OW-1:0] are the offset within the line (OW = log2(LINE_WORDS*4)), the next IW = log2(NUM_SETS) bits are the set index, and the remaining upper bits are the tag. With the defaults (4 sets, 4 words per line) the index is addr[5:4] and the tag is addr[31:6].
- R2: A request hits only when its set is valid and the stored tag equals the request tag. On a hit, rsp_hit is 1 in the same cycle and rsp_rdata is the word at offset/4. rsp_hit, rsp_miss and rsp_error are never high together.
- R3: A miss while no fill is active starts a fill of the line-aligned address. It answers rsp_miss with rsp_stall = nl_latency, or 1 when nl_latency is 0.
- R4: While a fill is active, a miss to any set answers rsp_miss with the fill's remaining count, which is never zero, and does not start a second fill.
- R5: The count decrements each cycle while it is above 1. At 1 the engine reads one line word per cycle in ascending order. With latency L and no next-level stalls, a retry made L+LINE_WORDS cycles after the starting miss hits, and a retry one cycle earlier misses with stall 1.
- R6: A next-level stall (nl_status = 2'b01) reloads the count with nl_stall (minimum 1). The engine then resumes at the same word.
- R7: An invalid-address answer (nl_status = 2'b10) is held. A retry to any word of that line gets rsp_error. A miss to a different line clears the error, answers rsp_miss with the fresh latency, and restarts the fill from word 0.
- R8: In the cycle after the last word arrives, the tag and the line data are installed, the set becomes valid, and fill_done is high for exactly one cycle with fill_tag and fill_index.
- R9: A write that hits updates the cached word and, in the same cycle, drives nl_wr_en with the word-aligned address and the data. A write that misses gives the miss response, forwards nothing, and starts a fill.
- R10: Reset clears every valid bit and any active fill. An address that was cached before reset then misses with a fresh stall count.
- R11: dbg_valid and dbg_tag report the valid bit and the stored tag of set dbg_set, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rsp_hit | output | 1 | Request hit |
| rsp_miss | output | 1 | Request missed; retry later |
| rsp_error | output | 1 | Line held an invalid-address error |
| rsp_rdata | output | DW | Read word on a hit |
| rsp_stall | output | SW | Stall count with a miss |
| nl_latency | input | SW | Next-level latency used to start fills |
| nl_rd_en | output | 1 | Fill word read to the next level |
| nl_wr_en | output | 1 | Write-through to the next level |
| nl_addr | output | AW | Word-aligned next-level address |
| nl_wdata | output | DW | Write-through data |
| nl_rdata | input | DW | Read data from the next level |
| nl_status | input | 2 | 00 ok, 01 stall, 10 invalid address |
| nl_stall | input | SW | Stall count with status 01 |
| fill_done | output | 1 | One-cycle fill-complete event |
| fill_tag | output | TW | Tag of the completed fill |
| fill_index | output | IW | Set of the completed fill |
| dbg_set | input | IW | Set selected for inspection |
| dbg_valid | output | 1 | Valid bit of dbg_set |
| dbg_tag | output | TW | Stored tag of dbg_set |

## Verification
The assertions run on every cycle. They check that at most one response kind is active, that a miss never reports a zero stall, that a fill-starting miss loads the countdown with the stall it reported, that a next-level stall reloads the countdown with its clamped value, and that a fill-done pulse releases the engine. Other behaviours can only be shown by the bench's scenarios. These are the exact cycle a retry first hits, resumption at the stalled word, the return of a held error to a same-line retry only, the data a write-through leaves behind, eviction by a conflicting tag, and the contents of the sets after reset.

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int NUM_SETS   = 4,
  parameter int LINE_WORDS = 4,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SW         = 8,
  localparam int IW = $clog2(NUM_SETS),
  localparam int WW = $clog2(LINE_WORDS),
  localparam int OW = WW + 2,
  localparam int TW = AW - IW - OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_hit,
  output logic          rsp_miss,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_rdata,
  output logic [SW-1:0] rsp_stall,
  input  logic [SW-1:0] nl_latency,
  output logic          nl_rd_en,
  output logic          nl_wr_en,
  output logic [AW-1:0] nl_addr,
  output logic [DW-1:0] nl_wdata,
  input  logic [DW-1:0] nl_rdata,
  input  logic [1:0]    nl_status,
  input  logic [SW-1:0] nl_stall,
  output logic          fill_done,
  output logic [TW-1:0] fill_tag,
  output logic [IW-1:0] fill_index,
  input  logic [IW-1:0] dbg_set,
  output logic          dbg_valid,
  output logic [TW-1:0] dbg_tag
);

  localparam logic [1:0] ST_OK    = 2'b00;
  localparam logic [1:0] ST_STALL = 2'b01;

  logic [NUM_SETS-1:0] valid_q;
  logic [TW-1:0]       tag_q  [NUM_SETS];
  logic [DW-1:0]       data_q [NUM_SETS][LINE_WORDS];
  logic [DW-1:0]       buf_q  [LINE_WORDS];

  logic          busy_q, err_q;
  logic [IW-1:0] f_idx_q;
  logic [TW-1:0] f_tag_q;
  logic [SW-1:0] cnt_q;
  logic [WW-1:0] widx_q;

  wire [TW-1:0] r_tag  = req_addr[AW-1 -: TW];
  wire [IW-1:0] r_idx  = req_addr[OW +: IW];
  wire [WW-1:0] r_word = req_addr[2 +: WW];
  wire          unused_lo = ^req_addr[1:0];

  wire [SW-1:0] lat1 = (nl_latency == '0) ? SW'(1) : nl_latency;
  wire [SW-1:0] stl1 = (nl_stall == '0) ? SW'(1) : nl_stall;

  wire lookup    = req_valid && valid_q[r_idx] && (tag_q[r_idx] == r_tag);
  wire same_line = busy_q && (f_idx_q == r_idx) && (f_tag_q == r_tag);
  wire missed    = req_valid && !lookup;
  wire start     = missed && !busy_q;
  wire restart   = missed && err_q && !same_line;
  wire last_word = nl_rd_en && (nl_status == ST_OK) && (widx_q == WW'(LINE_WORDS - 1));

  assign rsp_hit   = lookup;
  assign rsp_error = missed && err_q && same_line;
  assign rsp_miss  = missed && !rsp_error;
  assign rsp_stall = !rsp_miss ? '0 : (start || restart) ? lat1 : cnt_q;
  assign rsp_rdata = lookup ? data_q[r_idx][r_word] : '0;

  assign nl_wr_en = lookup && req_write;
  assign nl_wdata = req_wdata;
  assign nl_rd_en = busy_q && !err_q && (cnt_q == SW'(1)) && !nl_wr_en;
  assign nl_addr  = nl_wr_en ? {req_addr[AW-1:2], 2'b00} : {f_tag_q, f_idx_q, widx_q, 2'b00};

  assign dbg_valid = valid_q[dbg_set];
  assign dbg_tag   = tag_q[dbg_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      f_idx_q    <= '0;
      f_tag_q    <= '0;
      cnt_q      <= '0;
      widx_q     <= '0;
      fill_done  <= 1'b0;
      fill_tag   <= '0;
      fill_index <= '0;
    end else begin
      fill_done <= 1'b0;
      if (nl_wr_en) data_q[r_idx][r_word] <= req_wdata;
      if (start || restart) begin
        busy_q  <= 1'b1;
        err_q   <= 1'b0;
        f_idx_q <= r_idx;
        f_tag_q <= r_tag;
        cnt_q   <= lat1;
        widx_q  <= '0;
      end else if (busy_q && !err_q) begin
        if (cnt_q > SW'(1)) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (nl_rd_en) begin
          if (nl_status == ST_OK) begin
            buf_q[widx_q] <= nl_rdata;
            widx_q        <= widx_q + 1'b1;
            if (last_word) begin
              valid_q[f_idx_q] <= 1'b1;
              tag_q[f_idx_q]   <= f_tag_q;
              for (int w = 0; w < LINE_WORDS; w++)
                data_q[f_idx_q][w] <= (WW'(w) == widx_q) ? nl_rdata : buf_q[w];
              busy_q     <= 1'b0;
              fill_done  <= 1'b1;
              fill_tag   <= f_tag_q;
              fill_index <= f_idx_q;
            end
          end else if (nl_status == ST_STALL) begin
            cnt_q <= stl1;
          end else begin
            err_q <= 1'b1;
          end
        end
      end
    end
  end

  a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss, rsp_error}));

  a_r4_stall_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_stall != '0);

  a_r3_start_loads_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss && !busy_q) |=> busy_q && cnt_q == $past(rsp_stall));

  a_r6_stall_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_rd_en && nl_status == ST_STALL) |=>
      cnt_q == (($past(nl_stall) == '0) ? SW'(1) : $past(nl_stall)));

  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> !busy_q && $past(busy_q));

endmodule

// File: tb/dm_wt_cache_bench.sv
module dm_wt_cache_bench;
  localparam logic [31:0] K = 32'h5A5A_0000;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic rsp_hit, rsp_miss, rsp_error, nl_rd_en, nl_wr_en, fill_done, dbg_valid;
  logic [31:0] rsp_rdata, nl_addr, nl_wdata, nl_rdata;
  logic [7:0] rsp_stall, nl_stall;
  logic [1:0] nl_status;
  logic [25:0] fill_tag, dbg_tag;
  logic [1:0] fill_index, dbg_set = 0;

  bit inj_en = 0, bad_en = 0;
  logic [31:0] inj_addr = 0;
  logic [27:0] bad_line = 0;
  int wr_cnt = 0;
  logic [31:0] wr_addr = 0, wr_data = 0;

  assign nl_rdata = nl_addr ^ K;
  always_comb begin
    nl_status = 2'b00;
    nl_stall  = 8'd0;
    if (nl_rd_en) begin
      if (bad_en && nl_addr[31:4] == bad_line) nl_status = 2'b10;
      else if (inj_en && nl_addr == inj_addr) begin
        nl_status = 2'b01;
        nl_stall  = 8'd2;
      end
    end
  end
  always @(posedge clk) begin
    if (nl_rd_en && nl_status == 2'b01) inj_en <= 0;
    if (nl_wr_en) begin
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= nl_addr;
      wr_data <= nl_wdata;
    end
  end

  dm_wt_cache u_dm_wt_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .rsp_stall(rsp_stall), .nl_latency(8'(LAT)), .nl_rd_en(nl_rd_en),
    .nl_wr_en(nl_wr_en), .nl_addr(nl_addr), .nl_wdata(nl_wdata),
    .nl_rdata(nl_rdata), .nl_status(nl_status), .nl_stall(nl_stall),
    .fill_done(fill_done), .fill_tag(fill_tag), .fill_index(fill_index),
    .dbg_set(dbg_set), .dbg_valid(dbg_valid), .dbg_tag(dbg_tag)
  );

  int n_chk = 0, n_fail = 0;
  logic r_hit, r_miss, r_err, r_fd;
  logic [31:0] r_data;
  logic [7:0] r_stall;
  logic [25:0] r_ftag;
  logic [1:0] r_fidx;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic req(input logic [31:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_wdata = d;
    #1;
    r_hit = rsp_hit; r_miss = rsp_miss; r_err = rsp_error; r_data = rsp_rdata;
    r_stall = rsp_stall; r_fd = fill_done; r_ftag = fill_tag; r_fidx = fill_index;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] s);
    @(negedge clk);
    dbg_set = s;
    #1;
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic [31:0] d;
    logic [31:0] x;
  } vec_t;
  localparam vec_t VEC [8] = '{
    '{32'h0000_0104, 1'b0, 32'h0, 32'h0000_0104 ^ K},
    '{32'h0000_0108, 1'b0, 32'h0, 32'h0000_0108 ^ K},
    '{32'h0000_1134, 1'b0, 32'h0, 32'h0000_1134 ^ K},
    '{32'h0000_0100, 1'b1, 32'hDEAD_BEEF, 32'h0},
    '{32'h0000_0100, 1'b0, 32'h0, 32'hDEAD_BEEF},
    '{32'h0000_2124, 1'b0, 32'h0, 32'h0000_2124 ^ K},
    '{32'h0000_0214, 1'b0, 32'h0, 32'h0000_0214 ^ K},
    '{32'h0000_0140, 1'b0, 32'h0, 32'h0000_0140 ^ K}
  };

  bit finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int s = 0; s < 4; s++) begin
      peek(2'(s));
      chk("R10 reset valid clear", 32'(dbg_valid), 32'd0);
    end
    chk("R10 no fill event after reset", 32'(fill_done), 32'd0);

    req(32'h0000_0034, 0, 0);
    chk("R3 first miss", 32'(r_miss), 32'd1);
    chk("R3 first stall", 32'(r_stall), 32'(LAT));
    req(32'h0000_0010, 0, 0);
    chk("R4 other set miss", 32'(r_miss), 32'd1);
    chk("R4 other set remaining stall", 32'(r_stall), 32'(LAT));
    req(32'h0000_0034, 0, 0);
    chk("R5 countdown 2", 32'(r_stall), 32'd2);
    req(32'h0000_0034, 0, 0);
    chk("R5 countdown 1", 32'(r_stall), 32'd1);
    idle(2);
    req(32'h0000_0034, 0, 0);
    chk("R5 early retry misses", 32'(r_miss), 32'd1);
    chk("R5 early retry stall 1", 32'(r_stall), 32'd1);
    chk("R8 no event yet", 32'(r_fd), 32'd0);
    req(32'h0000_0034, 0, 0);
    chk("R5 retry hits at L+W", 32'(r_hit), 32'd1);
    chk("R2 hit data", r_data, 32'h0000_0034 ^ K);
    chk("R8 event pulse", 32'(r_fd), 32'd1);
    chk("R8 event tag", 32'(r_ftag), 32'd0);
    chk("R8 event index", 32'(r_fidx), 32'd3);
    req(32'h0000_0038, 0, 0);
    chk("R8 event single cycle", 32'(r_fd), 32'd0);
    chk("R2 neighbour word", r_data, 32'h0000_0038 ^ K);
    peek(2'd1);
    chk("R4 no second fill started", 32'(dbg_valid), 32'd0);
    peek(2'd3);
    chk("R11 debug valid", 32'(dbg_valid), 32'd1);
    chk("R11 debug tag", 32'(dbg_tag), 32'd0);

    for (int i = 0; i < 8; i++) begin
      int wc;
      wc = wr_cnt;
      req(VEC[i].a, VEC[i].w, VEC[i].d);
      if (r_miss) begin
        idle(LAT + 4 - 1);
        req(VEC[i].a, VEC[i].w, VEC[i].d);
      end
      chk("R2 table hit", 32'(r_hit), 32'd1);
      if (VEC[i].w) begin
        chk("R9 table write forwarded", 32'(wr_cnt), 32'(wc + 1));
        chk("R9 table write data", wr_data, VEC[i].d);
        chk("R9 table write addr", wr_addr, VEC[i].a & ~32'h3);
      end else begin
        chk("R2 table read data", r_data, VEC[i].x);
      end
    end
    peek(2'd0);
    chk("R1 conflict replaced tag", 32'(dbg_tag), 32'd5);
    req(32'h0000_0104, 0, 0);
    chk("R1 evicted line misses", 32'(r_miss), 32'd1);
    idle(LAT + 4 - 1);

    begin
      int wc;
      wc = wr_cnt;
      req(32'h0000_3008, 1, 32'h1234_5678);
      chk("R9 write miss", 32'(r_miss), 32'd1);
      chk("R9 write miss not forwarded", 32'(wr_cnt), 32'(wc));
      idle(LAT + 4 - 1);
      req(32'h0000_3008, 1, 32'h1234_5678);
      chk("R9 write retry hits", 32'(r_hit), 32'd1);
      chk("R9 write forwarded", wr_data, 32'h1234_5678);
      req(32'h0000_3008, 0, 0);
      chk("R9 written word cached", r_data, 32'h1234_5678);
      req(32'h0000_300C, 0, 0);
      chk("R9 other words untouched", r_data, 32'h0000_300C ^ K);
    end

    inj_addr = 32'h0000_0458; inj_en = 1;
    req(32'h0000_0458, 0, 0);
    idle(5);
    req(32'h0000_0458, 0, 0);
    chk("R6 reloaded count", 32'(r_stall), 32'd2);
    req(32'h0000_0458, 0, 0);
    chk("R6 count down", 32'(r_stall), 32'd1);
    req(32'h0000_0458, 0, 0);
    chk("R6 still filling", 32'(r_miss), 32'd1);
    req(32'h0000_0458, 0, 0);
    chk("R6 hit after resume", 32'(r_hit), 32'd1);
    chk("R6 stalled word data", r_data, 32'h0000_0458 ^ K);
    req(32'h0000_0450, 0, 0);
    chk("R6 earlier word data", r_data, 32'h0000_0450 ^ K);

    bad_line = 28'h000_0056; bad_en = 1;
    req(32'h0000_0560, 0, 0);
    idle(3);
    req(32'h0000_0560, 0, 0);
    chk("R7 same line error", 32'(r_err), 32'd1);
    req(32'h0000_0568, 0, 0);
    chk("R7 other word same line error", 32'(r_err), 32'd1);
    req(32'h0000_0724, 0, 0);
    chk("R7 new line miss", 32'(r_miss), 32'd1);
    chk("R7 new line fresh stall", 32'(r_stall), 32'(LAT));
    bad_en = 0;
    idle(LAT + 4 - 1);
    req(32'h0000_0724, 0, 0);
    chk("R7 new line hits", 32'(r_hit), 32'd1);
    chk("R7 new line data", r_data, 32'h0000_0724 ^ K);
    chk("R8 event tag new line", 32'(r_ftag), 32'h1C);
    chk("R8 event index new line", 32'(r_fidx), 32'd2);

    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    for (int s = 0; s < 4; s++) begin
      peek(2'(s));
      chk("R10 valid cleared by reset", 32'(dbg_valid), 32'd0);
    end
    req(32'h0000_0724, 0, 0);
    chk("R10 cached line misses", 32'(r_miss), 32'd1);
    chk("R10 fresh stall", 32'(r_stall), 32'(LAT));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule